// File: doc/BRIEF.md
# Three-Port Multiplexed Transparent Latch

This block joins one wide data bus, port A, to two bank buses, B1 and B2, and carries data either way. From the banks to A, each bank input passes through its own transparent latch. A select input then picks which of the two latch outputs reaches A. From A to the banks, A feeds two further transparent latches, and each of them drives one bank. Typical uses are interleaving two memory banks, or splitting a shared address/data bus into separate address and data paths and joining them again.

The bidirectional pins are split into an input vector, an output vector and an output-enable flag for each port. This keeps the block synthesizable and lets the surrounding pad logic resolve the tri-state. Every output port has its own active-low enable. The two bank enables are independent, so one bank can be driven while the other floats. Each latch is built as a clocked holding register with a bypass. While its enable is high the latch output follows the live input in the same cycle. Once the enable drops, the output holds the value that was sampled at the last rising clock edge on which the enable was high.

Top module: `tri_port_latch_mux`

## Requirements
- R1: A synchronous active-high reset clears all four holding registers to zero. An enabled output port whose latch is closed then reads zero.
- R2: While a latch enable is high, the output it feeds shows that latch's live input in the same cycle, with no clock delay.
- R3: After a latch enable falls, the latch output holds the input sampled at the last rising edge with the enable high. It ignores later changes on that input.
- R4: With `sel_b1` = 1 the A output takes the bank-1 to A latch. With `sel_b1` = 0 it takes the bank-2 to A latch.
- R5: `a_oe` is the inverse of `a_oe_n`. While `a_oe_n` = 1, `a_out` is forced to all zeros.
- R6: `b1_oe`/`b1_out` are controlled by `b1_oe_n` alone, and `b2_oe`/`b2_out` by `b2_oe_n` alone. A disabled bank output is forced to zero, while the other bank stays driven.
- R7: The two A-to-bank latches are independent. Opening or closing one does not change the value the other holds or shows.
- R8: The two bank-to-A latches hold their values independently. Changing `sel_b1` while both are closed switches A between the two held values, and neither is disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven onto port A |
| a_oe | output | 1 | Port A driver enable (1 = drive) |
| b1_in | input | W | Data arriving on bank 1 |
| b1_out | output | W | Data driven onto bank 1 |
| b1_oe | output | 1 | Bank 1 driver enable |
| b2_in | input | W | Data arriving on bank 2 |
| b2_out | output | W | Data driven onto bank 2 |
| b2_oe | output | 1 | Bank 2 driver enable |
| sel_b1 | input | 1 | 1 = bank 1 path to A, 0 = bank 2 path to A |
| le_b1_to_a | input | 1 | Latch enable, bank 1 to A latch |
| le_b2_to_a | input | 1 | Latch enable, bank 2 to A latch |
| le_a_to_b1 | input | 1 | Latch enable, A to bank 1 latch |
| le_a_to_b2 | input | 1 | Latch enable, A to bank 2 latch |
| a_oe_n | input | 1 | Active-low enable for port A |
| b1_oe_n | input | 1 | Active-low enable for bank 1 |
| b2_oe_n | input | 1 | Active-low enable for bank 2 |

## Verification
The hardest state to reach is the one where both bank-to-A latches are closed and hold different values. Only then does a change of select show that each latch keeps its own contents. To get there, the stimulus opens both latches with distinct bank values, closes them, then reopens only one with a third value before closing it again. It then toggles the select while the bank inputs carry unrelated values. The A-to-bank side gets the same treatment by staggering the two enables. The bench also keeps port A disabled whenever a bank is enabled, and counts any cycle where both directions drive at once.

// File: rtl/tri_port_latch_pkg.sv
package tri_port_latch_pkg;

    localparam int unsigned LATCH_W_DFLT = 12;
    localparam int unsigned NUM_BANKS    = 2;

    typedef enum logic [0:0] {
        BANK_1 = 1'b0,
        BANK_2 = 1'b1
    } bank_e;

    // Control bundle steering the datapath.
    typedef struct packed {
        logic                 sel_bank1;
        logic [NUM_BANKS-1:0] le_to_a;
        logic [NUM_BANKS-1:0] le_to_bank;
        logic                 a_dis;
        logic [NUM_BANKS-1:0] bank_dis;
    } ctrl_t;

    function automatic bank_e pick_bank(input logic sel_bank1);
        return sel_bank1 ? BANK_1 : BANK_2;
    endfunction

endpackage

// File: rtl/latch_cell.sv
module latch_cell #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (le) begin
            held_q <= d;
        end
    end

    // Transparent while open, holding while closed.
    always_comb begin
        q = le ? d : held_q;
    end
endmodule

// File: rtl/port_gate.sv
module port_gate #(
    parameter int unsigned W = 12
) (
    input  logic         dis_n_low,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         oe
);
    always_comb begin
        oe = ~dis_n_low;
        q  = dis_n_low ? '0 : d;
    end
endmodule

// File: rtl/bank_to_a_path.sv
module bank_to_a_path
    import tri_port_latch_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_BANKS-1:0][W-1:0]  bank_d,
    input  logic [NUM_BANKS-1:0]         le,
    input  logic                         sel_bank1,
    output logic [W-1:0]                 merged
);
    logic [NUM_BANKS-1:0][W-1:0] lat_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_lat
        latch_cell #(.W(W)) cell_i (
            .clk (clk),
            .rst (rst),
            .le  (le[g]),
            .d   (bank_d[g]),
            .q   (lat_q[g])
        );
    end

    always_comb begin
        merged = lat_q[pick_bank(sel_bank1)];
    end
endmodule

// File: rtl/a_to_bank_path.sv
module a_to_bank_path
    import tri_port_latch_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [W-1:0]                 a_d,
    input  logic [NUM_BANKS-1:0]         le,
    output logic [NUM_BANKS-1:0][W-1:0]  bank_q
);
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_lat
        latch_cell #(.W(W)) cell_i (
            .clk (clk),
            .rst (rst),
            .le  (le[g]),
            .d   (a_d),
            .q   (bank_q[g])
        );
    end
endmodule

// File: rtl/tri_port_latch_mux.sv
module tri_port_latch_mux
    import tri_port_latch_pkg::*;
#(
    parameter int unsigned W = LATCH_W_DFLT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic         b1_oe,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic         b2_oe,
    input  logic         sel_b1,
    input  logic         le_b1_to_a,
    input  logic         le_b2_to_a,
    input  logic         le_a_to_b1,
    input  logic         le_a_to_b2,
    input  logic         a_oe_n,
    input  logic         b1_oe_n,
    input  logic         b2_oe_n
);
    ctrl_t                       ctrl;
    logic [NUM_BANKS-1:0][W-1:0] bank_d;
    logic [NUM_BANKS-1:0][W-1:0] bank_q;
    logic [NUM_BANKS-1:0][W-1:0] bank_o;
    logic [NUM_BANKS-1:0]        bank_oe;
    logic [W-1:0]                merged;

    always_comb begin
        ctrl.sel_bank1  = sel_b1;
        ctrl.le_to_a    = {le_b2_to_a, le_b1_to_a};
        ctrl.le_to_bank = {le_a_to_b2, le_a_to_b1};
        ctrl.a_dis      = a_oe_n;
        ctrl.bank_dis   = {b2_oe_n, b1_oe_n};
        bank_d          = {b2_in, b1_in};
    end

    bank_to_a_path #(.W(W)) to_a_i (
        .clk       (clk),
        .rst       (rst),
        .bank_d    (bank_d),
        .le        (ctrl.le_to_a),
        .sel_bank1 (ctrl.sel_bank1),
        .merged    (merged)
    );

    a_to_bank_path #(.W(W)) to_bank_i (
        .clk    (clk),
        .rst    (rst),
        .a_d    (a_in),
        .le     (ctrl.le_to_bank),
        .bank_q (bank_q)
    );

    port_gate #(.W(W)) gate_a_i (
        .dis_n_low (ctrl.a_dis),
        .d         (merged),
        .q         (a_out),
        .oe        (a_oe)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_gate
        port_gate #(.W(W)) gate_i (
            .dis_n_low (ctrl.bank_dis[g]),
            .d         (bank_q[g]),
            .q         (bank_o[g]),
            .oe        (bank_oe[g])
        );
    end

    always_comb begin
        b1_out = bank_o[0];
        b2_out = bank_o[1];
        b1_oe  = bank_oe[0];
        b2_oe  = bank_oe[1];
    end
endmodule

// File: rtl/tri_port_latch_chk.sv
module tri_port_latch_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b1_in,
    input logic [W-1:0] b1_out,
    input logic         b1_oe,
    input logic [W-1:0] b2_in,
    input logic [W-1:0] b2_out,
    input logic         b2_oe,
    input logic         sel_b1,
    input logic         le_b1_to_a,
    input logic         le_b2_to_a,
    input logic         le_a_to_b1,
    input logic         le_a_to_b2,
    input logic         a_oe_n,
    input logic         b1_oe_n,
    input logic         b2_oe_n
);
    p_transp_b1_r2: assert property (@(posedge clk) disable iff (rst)
        (le_a_to_b1 && !b1_oe_n) |-> (b1_out == a_in));

    p_transp_b2_r2: assert property (@(posedge clk) disable iff (rst)
        (le_a_to_b2 && !b2_oe_n) |-> (b2_out == a_in));

    p_hold_b1_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !le_a_to_b1 && !$past(le_a_to_b1)
         && !b1_oe_n && !$past(b1_oe_n)) |-> $stable(b1_out));

    p_hold_a_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !le_b1_to_a && !$past(le_b1_to_a) && !le_b2_to_a
         && !$past(le_b2_to_a) && !a_oe_n && !$past(a_oe_n)
         && $stable(sel_b1)) |-> $stable(a_out));

    p_sel1_r4: assert property (@(posedge clk) disable iff (rst)
        (sel_b1 && le_b1_to_a && !a_oe_n) |-> (a_out == b1_in));

    p_sel2_r4: assert property (@(posedge clk) disable iff (rst)
        (!sel_b1 && le_b2_to_a && !a_oe_n) |-> (a_out == b2_in));

    p_a_off_r5: assert property (@(posedge clk) disable iff (rst)
        a_oe_n |-> (!a_oe && a_out == '0));

    p_b1_off_r6: assert property (@(posedge clk) disable iff (rst)
        b1_oe_n |-> (!b1_oe && b1_out == '0));

    p_b2_off_r6: assert property (@(posedge clk) disable iff (rst)
        b2_oe_n |-> (!b2_oe && b2_out == '0));
endmodule

bind tri_port_latch_mux tri_port_latch_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b1_in      (b1_in),
    .b1_out     (b1_out),
    .b1_oe      (b1_oe),
    .b2_in      (b2_in),
    .b2_out     (b2_out),
    .b2_oe      (b2_oe),
    .sel_b1     (sel_b1),
    .le_b1_to_a (le_b1_to_a),
    .le_b2_to_a (le_b2_to_a),
    .le_a_to_b1 (le_a_to_b1),
    .le_a_to_b2 (le_a_to_b2),
    .a_oe_n     (a_oe_n),
    .b1_oe_n    (b1_oe_n),
    .b2_oe_n    (b2_oe_n)
);

// File: tb/tri_port_latch_mux_tb_top.sv
module tri_port_latch_mux_tb_top;
    localparam int unsigned W = 12;

    typedef struct packed {
        logic         sel;
        logic         lb1;
        logic         lb2;
        logic         la1;
        logic         la2;
        logic         aoen;
        logic         b1oen;
        logic         b2oen;
        logic [W-1:0] a;
        logic [W-1:0] b1;
        logic [W-1:0] b2;
        logic [W-1:0] ea;
        logic [W-1:0] eb1;
        logic [W-1:0] eb2;
    } vec_t;

    localparam int N_VEC = 17;
    localparam vec_t TBL [N_VEC] = '{
        // R1: reset contents seen through A, both selects; banks off
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'hABC,12'h111,12'h222, 12'h000,12'h000,12'h000},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'hABC,12'h111,12'h222, 12'h000,12'h000,12'h000},
        // R1 R5: A off, banks on, bank latches still zero
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 12'hABC,12'h111,12'h222, 12'h000,12'h000,12'h000},
        // R2 R4: both bank latches open, sel bank 1
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'h123,12'h456, 12'h123,12'h000,12'h000},
        // R2 R4: sel bank 2
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'h123,12'h456, 12'h456,12'h000,12'h000},
        // R3: closed, inputs change, held 0x123
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'hFFF,12'h000, 12'h123,12'h000,12'h000},
        // R3 R4: held 0x456
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'hFFF,12'h000, 12'h456,12'h000,12'h000},
        // R2: reopen bank 2 latch only with 0x777
        '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'hFFF,12'h777, 12'h777,12'h000,12'h000},
        // R8: bank 1 latch undisturbed
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'h0F0,12'h001, 12'h123,12'h000,12'h000},
        // R8: bank 2 latch now 0x777
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 12'h000,12'h0F0,12'h001, 12'h777,12'h000,12'h000},
        // R5: A disabled, forced zero
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 12'h000,12'h0F0,12'h001, 12'h000,12'h000,12'h000},
        // R2: both A-to-bank latches open
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 12'h0F0,12'h000,12'h000, 12'h000,12'h0F0,12'h0F0},
        // R7: close bank 1 latch, bank 2 follows
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 12'hA5A,12'h000,12'h000, 12'h000,12'h0F0,12'hA5A},
        // R7: close bank 2, reopen bank 1
        '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 12'h3C3,12'h000,12'h000, 12'h000,12'h3C3,12'hA5A},
        // R3: both closed, A changes
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 12'h000,12'h000,12'h000, 12'h000,12'h3C3,12'hA5A},
        // R6: bank 1 off, bank 2 on
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 12'h000,12'h000,12'h000, 12'h000,12'h000,12'hA5A},
        // R6: bank 1 on, bank 2 off
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 12'h000,12'h000,12'h000, 12'h000,12'h3C3,12'h000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
    logic [W-1:0] a_out, b1_out, b2_out;
    logic         a_oe, b1_oe, b2_oe;
    logic         sel_b1 = 1'b0;
    logic         le_b1_to_a = 1'b0, le_b2_to_a = 1'b0;
    logic         le_a_to_b1 = 1'b0, le_a_to_b2 = 1'b0;
    logic         a_oe_n = 1'b1, b1_oe_n = 1'b1, b2_oe_n = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    int n_contend = 0;

    always #10 clk = ~clk;

    tri_port_latch_mux #(.W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
        .sel_b1(sel_b1),
        .le_b1_to_a(le_b1_to_a), .le_b2_to_a(le_b2_to_a),
        .le_a_to_b1(le_a_to_b1), .le_a_to_b2(le_a_to_b2),
        .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n)
    );

    // Usage monitor: A and a bank both enabled is bus contention.
    always @(negedge clk) begin
        if (!rst && !a_oe_n && (!b1_oe_n || !b2_oe_n)) n_contend++;
    end

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        sel_b1 = v.sel; le_b1_to_a = v.lb1; le_b2_to_a = v.lb2;
        le_a_to_b1 = v.la1; le_a_to_b2 = v.la2;
        a_oe_n = v.aoen; b1_oe_n = v.b1oen; b2_oe_n = v.b2oen;
        a_in = v.a; b1_in = v.b1; b2_in = v.b2;
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            apply(TBL[i]);
            #5;
            check($sformatf("table step %0d a_out", i),  a_out,  TBL[i].ea);
            check($sformatf("table step %0d b1_out", i), b1_out, TBL[i].eb1);
            check($sformatf("table step %0d b2_out", i), b2_out, TBL[i].eb2);
            check($sformatf("R5 step %0d a_oe", i),  {{(W-1){1'b0}}, a_oe},  {{(W-1){1'b0}}, ~TBL[i].aoen});
            check($sformatf("R6 step %0d b1_oe", i), {{(W-1){1'b0}}, b1_oe}, {{(W-1){1'b0}}, ~TBL[i].b1oen});
            check($sformatf("R6 step %0d b2_oe", i), {{(W-1){1'b0}}, b2_oe}, {{(W-1){1'b0}}, ~TBL[i].b2oen});
        end

        // R3: input changes in the same cycle the enable falls; held value is the edge sample
        @(negedge clk);
        a_oe_n = 1'b1; b1_oe_n = 1'b0; b2_oe_n = 1'b1;
        le_a_to_b1 = 1'b1; a_in = 12'h5AA;
        @(negedge clk);
        le_a_to_b1 = 1'b0; a_in = 12'h0FF;
        #5;
        check("R3 capture at last open edge b1_out", b1_out, 12'h5AA);
        @(negedge clk);
        a_in = 12'hC00;
        #5;
        check("R3 hold after more edges b1_out", b1_out, 12'h5AA);

        // R1: reset in mid-run clears every latch
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        b1_oe_n = 1'b0; b2_oe_n = 1'b0;
        #5;
        check("R1 b1_out after reset", b1_out, '0);
        check("R1 b2_out after reset", b2_out, '0);
        @(negedge clk);
        b1_oe_n = 1'b1; b2_oe_n = 1'b1; a_oe_n = 1'b0; sel_b1 = 1'b1;
        b1_in = 12'hFFF; b2_in = 12'hFFF;
        #5;
        check("R1 a_out sel bank1 after reset", a_out, '0);
        sel_b1 = 1'b0;
        #1;
        check("R1 a_out sel bank2 after reset", a_out, '0);

        check("usage: contention cycles", n_contend[W-1:0], '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule